// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block holds the value and flag rules of an 8-bit accumulator processor's arithmetic unit. In each operation it combines the accumulator with a second byte, or a register pair with another pair, and returns the new value together with four condition flags: zero, subtract, half-carry and carry. A two-bit class selects the operation group. Class 0 holds the eight two-operand byte operations. Class 1 holds the single-operand accumulator and flag operations. Class 2 is a 16-bit pair addition. Class 3 is a no-operation.

The flags enter as a 4-bit vector and leave packed into a flag byte. Each group follows its own rules on which flags it writes and which it keeps. The datapath has no registers. A valid strobe qualifies each request. By default an output register presents each result one clock later, with write enables that name which destination the caller should update. The register file, memory, fetch and sequencing are all outside this block.

Top module: `acc_alu`

## Requirements
- R1: After reset, `out_valid` is 0. Each cycle, `out_valid` equals `in_valid` from the previous cycle, and the result fields at that point belong to that request.
- R2: `flags_in` is {zero, subtract, half, carry} in bits 3..0. `flags_out` places zero in bit 7, subtract in bit 6, half in bit 5 and carry in bit 4, and bits 3..0 always read 0. Whenever `acc_we` is 0, `res_byte` equals `acc_in`. Whenever `pair_we` is 0, `res_word` is 0.
- R3: Class 0 with `alu_sel` 0 (add) or 1 (add with carry) forms the 9-bit sum of acc, operand and, for select 1 only, the carry input. The result is the low byte, with C = bit 8, H = carry out of bit 3, N = 0, Z = (result == 0), and `acc_we` = 1.
- R4: Class 0 with `alu_sel` 2 (subtract) or 3 (subtract with borrow) forms the 9-bit difference acc − operand − (carry input, for select 3 only). The result is the low byte, with C = borrow out of bit 7, H = borrow into bit 4, N = 1, Z = (result == 0), and `acc_we` = 1.
- R5: Class 0 with `alu_sel` 7 (compare) sets the flags exactly as subtract does, but `acc_we` = 0 and `res_byte` keeps the accumulator.
- R6: Class 0 with `alu_sel` 4 (AND) gives H = 1. Selects 5 (XOR) and 6 (OR) give H = 0. All three give C = 0, N = 0, Z from the result, and `acc_we` = 1.
- R7: Class 1 with `misc_sel` 0 increments the accumulator, giving N = 0 and H = (low nibble of the result == 0). `misc_sel` 1 decrements it, giving N = 1 and H = (low nibble of the result == 0xF). Both keep C, set Z from the result, and give `acc_we` = 1.
- R8: Class 1 with `misc_sel` 2 is the decimal adjust. The low fix applies when H is set or the low nibble exceeds 9. The high fix applies when C is set or acc exceeds 0x99. Each fix adds 0x06 or 0x60 when N = 0, and subtracts it when N = 1. C becomes the high-fix condition, H becomes 0, N is kept, Z comes from the result, and `acc_we` = 1.
- R9: Class 1 with `misc_sel` 3 inverts acc, sets H and N, keeps Z and C, and gives `acc_we` = 1. `misc_sel` 4 sets C. `misc_sel` 5 inverts C. Selects 4 and 5 both clear H and N, keep Z, and give `acc_we` = 0.
- R10: Class 1 with `misc_sel` 6 or 7, and class 3, have no effect: `flags_out` carries `flags_in` unchanged, `res_byte` = `acc_in`, and both write enables are 0.
- R11: Class 2 outputs `pair_a + pair_b` mod 2^16 on `res_word` with `pair_we` = 1 and `acc_we` = 0. C = carry out of bit 15, H = carry out of bit 11, N = 0, and Z is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_class | input | 2 | Operation group: 0 byte ALU, 1 accumulator/flag op, 2 pair add, 3 none |
| alu_sel | input | 3 | Byte ALU op: 0 add, 1 adc, 2 sub, 3 sbc, 4 and, 5 xor, 6 or, 7 compare |
| misc_sel | input | 3 | 0 inc, 1 dec, 2 decimal adjust, 3 invert, 4 set carry, 5 flip carry, 6/7 none |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second byte operand |
| pair_a | input | 16 | Destination pair value for the 16-bit add |
| pair_b | input | 16 | Source pair value for the 16-bit add |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result strobe |
| acc_we | output | 1 | `res_byte` should be written to the accumulator |
| pair_we | output | 1 | `res_word` should be written to the destination pair |
| res_byte | output | 8 | Byte result |
| res_word | output | 16 | Pair result |
| flags_out | output | 8 | New flag byte, Z/N/H/C in bits 7..4 |

## Verification
Every result, flag byte and write enable belongs to the request presented one rising edge earlier. `out_valid` follows the strobe with that same one-cycle delay. The bench therefore drives a request on a falling edge and compares the outputs on the next falling edge, half a period after the capturing edge. It then drives the next request in the same instant. This keeps exactly one request in flight per instance, so every comparison lines up with a known expectation. Idle cycles placed between requests confirm that `out_valid` drops one cycle after the strobe does.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [1:0] {
      CLS_BYTE = 2'd0,
      CLS_MISC = 2'd1,
      CLS_WORD = 2'd2,
      CLS_NONE = 2'd3
   } op_class_e;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_ADC = 3'd1,
      ALU_SUB = 3'd2,
      ALU_SBC = 3'd3,
      ALU_AND = 3'd4,
      ALU_XOR = 3'd5,
      ALU_OR  = 3'd6,
      ALU_CP  = 3'd7
   } alu_sel_e;

   typedef enum logic [2:0] {
      MSC_INC  = 3'd0,
      MSC_DEC  = 3'd1,
      MSC_DAA  = 3'd2,
      MSC_CPL  = 3'd3,
      MSC_SCF  = 3'd4,
      MSC_CCF  = 3'd5,
      MSC_RSV6 = 3'd6,
      MSC_RSV7 = 3'd7
   } misc_sel_e;

   // flag vector order matches the flags_in port: {z,n,h,c}
   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   // bit positions inside the packed flag byte
   localparam int FLAG_BYTE_W = 8;
   localparam int FB_Z = 7;
   localparam int FB_N = 6;
   localparam int FB_H = 5;
   localparam int FB_C = 4;

   function automatic logic [FLAG_BYTE_W-1:0] pack_flags(input flags_t f);
      logic [FLAG_BYTE_W-1:0] p;
      p       = '0;
      p[FB_Z] = f.z;
      p[FB_N] = f.n;
      p[FB_H] = f.h;
      p[FB_C] = f.c;
      return p;
   endfunction

endpackage

// File: rtl/acc_alu_byte.sv
module acc_alu_byte
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_sel_e          sel,
   input  logic              cy_in,
   output logic [DATA_W-1:0] res,
   output logic              wr,
   output flags_t            fout
);

   localparam int NIB = 4;

   logic              cin;
   logic [DATA_W:0]   sum, dif;
   logic [NIB:0]      nsum, ndif;
   logic [DATA_W-1:0] lres;

   always_comb begin
      cin  = cy_in & ((sel == ALU_ADC) | (sel == ALU_SBC));
      sum  = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
      dif  = {1'b0, a} - {1'b0, b} - (DATA_W+1)'(cin);
      nsum = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + (NIB+1)'(cin);
      ndif = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - (NIB+1)'(cin);

      fout = '0;
      lres = '0;
      unique case (sel)
         ALU_ADD, ALU_ADC: begin
            lres   = sum[DATA_W-1:0];
            fout.c = sum[DATA_W];
            fout.h = nsum[NIB];
         end
         ALU_SUB, ALU_SBC, ALU_CP: begin
            lres   = dif[DATA_W-1:0];
            fout.n = 1'b1;
            fout.c = dif[DATA_W];
            fout.h = ndif[NIB];
         end
         ALU_AND: begin
            lres   = a & b;
            fout.h = 1'b1;
         end
         ALU_XOR: lres = a ^ b;
         ALU_OR:  lres = a | b;
         default: lres = a;
      endcase
      fout.z = (lres == '0);

      wr  = (sel != ALU_CP);
      res = wr ? lres : a;
   end

endmodule

// File: rtl/acc_alu_misc.sv
module acc_alu_misc
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  misc_sel_e         sel,
   input  flags_t            fin,
   output logic [DATA_W-1:0] res,
   output logic              wr,
   output flags_t            fout
);

   localparam int                NIB       = 4;
   localparam logic [NIB-1:0]    NIB_LIM   = 4'd9;
   localparam logic [DATA_W-1:0] BYTE_LIM  = DATA_W'(8'h99);
   localparam logic [NIB-1:0]    FIX_DIGIT = 4'h6;

   logic              lo_fix, hi_fix;
   logic [DATA_W-1:0] adj;

   always_comb begin
      lo_fix = fin.h | (a[NIB-1:0] > NIB_LIM);
      hi_fix = fin.c | (a > BYTE_LIM);
      adj    = '0;
      if (lo_fix) adj[NIB-1:0]     = FIX_DIGIT;
      if (hi_fix) adj[2*NIB-1:NIB] = FIX_DIGIT;

      fout = fin;
      res  = a;
      wr   = 1'b0;
      unique case (sel)
         MSC_INC: begin
            res    = a + DATA_W'(1);
            wr     = 1'b1;
            fout.n = 1'b0;
            fout.h = (res[NIB-1:0] == '0);
            fout.z = (res == '0);
         end
         MSC_DEC: begin
            res    = a - DATA_W'(1);
            wr     = 1'b1;
            fout.n = 1'b1;
            fout.h = (res[NIB-1:0] == '1);
            fout.z = (res == '0);
         end
         MSC_DAA: begin
            res    = fin.n ? (a - adj) : (a + adj);
            wr     = 1'b1;
            fout.c = hi_fix;
            fout.h = 1'b0;
            fout.z = (res == '0);
         end
         MSC_CPL: begin
            res    = ~a;
            wr     = 1'b1;
            fout.h = 1'b1;
            fout.n = 1'b1;
         end
         MSC_SCF: begin
            fout.c = 1'b1;
            fout.h = 1'b0;
            fout.n = 1'b0;
         end
         MSC_CCF: begin
            fout.c = ~fin.c;
            fout.h = 1'b0;
            fout.n = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_word.sv
module acc_alu_word
   import acc_alu_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] pa,
   input  logic [WORD_W-1:0] pb,
   input  logic              z_in,
   output logic [WORD_W-1:0] res,
   output flags_t            fout
);

   // half-carry comes from the nibble boundary inside the upper byte
   localparam int HB = WORD_W - 4;

   logic [WORD_W:0] full;
   logic [HB:0]     part;

   always_comb begin
      full   = {1'b0, pa} + {1'b0, pb};
      part   = {1'b0, pa[HB-1:0]} + {1'b0, pb[HB-1:0]};
      res    = full[WORD_W-1:0];
      fout.z = z_in;
      fout.n = 1'b0;
      fout.h = part[HB];
      fout.c = full[WORD_W];
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [1:0]             op_class,
   input  logic [2:0]             alu_sel,
   input  logic [2:0]             misc_sel,
   input  logic [DATA_W-1:0]      acc_in,
   input  logic [DATA_W-1:0]      opnd_in,
   input  logic [2*DATA_W-1:0]    pair_a,
   input  logic [2*DATA_W-1:0]    pair_b,
   input  logic [3:0]             flags_in,
   output logic                   out_valid,
   output logic                   acc_we,
   output logic                   pair_we,
   output logic [DATA_W-1:0]      res_byte,
   output logic [2*DATA_W-1:0]    res_word,
   output logic [FLAG_BYTE_W-1:0] flags_out
);

   localparam int WORD_W = 2 * DATA_W;

   // the decimal-adjust constants and the flag byte assume byte lanes
   if (DATA_W != 8) begin : g_width_chk
      $error("acc_alu: DATA_W must be 8");
   end

   flags_t fin;
   assign fin = flags_t'(flags_in);

   logic [DATA_W-1:0] b_res, m_res;
   logic              b_wr, m_wr;
   flags_t            b_fl, m_fl, w_fl;
   logic [WORD_W-1:0] w_res;

   acc_alu_byte #(.DATA_W(DATA_W)) u_byte (
      .a     (acc_in),
      .b     (opnd_in),
      .sel   (alu_sel_e'(alu_sel)),
      .cy_in (fin.c),
      .res   (b_res),
      .wr    (b_wr),
      .fout  (b_fl)
   );

   acc_alu_misc #(.DATA_W(DATA_W)) u_misc (
      .a    (acc_in),
      .sel  (misc_sel_e'(misc_sel)),
      .fin  (fin),
      .res  (m_res),
      .wr   (m_wr),
      .fout (m_fl)
   );

   acc_alu_word #(.WORD_W(WORD_W)) u_word (
      .pa   (pair_a),
      .pb   (pair_b),
      .z_in (fin.z),
      .res  (w_res),
      .fout (w_fl)
   );

   logic [DATA_W-1:0]      nxt_byte;
   logic [WORD_W-1:0]      nxt_word;
   logic                   nxt_acc_we, nxt_pair_we;
   flags_t                 nxt_fl;
   logic [FLAG_BYTE_W-1:0] nxt_fbyte;

   always_comb begin
      nxt_byte    = acc_in;
      nxt_word    = '0;
      nxt_acc_we  = 1'b0;
      nxt_pair_we = 1'b0;
      nxt_fl      = fin;
      unique case (op_class_e'(op_class))
         CLS_BYTE: begin
            nxt_byte   = b_res;
            nxt_acc_we = b_wr;
            nxt_fl     = b_fl;
         end
         CLS_MISC: begin
            nxt_byte   = m_res;
            nxt_acc_we = m_wr;
            nxt_fl     = m_fl;
         end
         CLS_WORD: begin
            nxt_word    = w_res;
            nxt_pair_we = 1'b1;
            nxt_fl      = w_fl;
         end
         default: ;
      endcase
      nxt_fbyte = pack_flags(nxt_fl);
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            acc_we    <= 1'b0;
            pair_we   <= 1'b0;
            res_byte  <= '0;
            res_word  <= '0;
            flags_out <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               acc_we    <= nxt_acc_we;
               pair_we   <= nxt_pair_we;
               res_byte  <= nxt_byte;
               res_word  <= nxt_word;
               flags_out <= nxt_fbyte;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign acc_we    = nxt_acc_we;
      assign pair_we   = nxt_pair_we;
      assign res_byte  = nxt_byte;
      assign res_word  = nxt_word;
      assign flags_out = nxt_fbyte;
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [1:0]             op_class,
   input logic [2:0]             alu_sel,
   input logic [2:0]             misc_sel,
   input logic [DATA_W-1:0]      acc_in,
   input logic [3:0]             flags_in,
   input logic                   out_valid,
   input logic                   acc_we,
   input logic                   pair_we,
   input logic [DATA_W-1:0]      res_byte,
   input logic [FLAG_BYTE_W-1:0] flags_out
);

   // request as it stood when the present outputs were formed
   logic              q_valid;
   logic [1:0]        q_cls;
   logic [2:0]        q_alu, q_msc;
   logic [DATA_W-1:0] q_acc;
   logic [3:0]        q_fin;

   if (REG_OUT) begin : g_q_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_valid <= 1'b0;
         else        q_valid <= in_valid;
      end
      always_ff @(posedge clk) begin
         q_cls <= op_class;
         q_alu <= alu_sel;
         q_msc <= misc_sel;
         q_acc <= acc_in;
         q_fin <= flags_in;
      end
   end else begin : g_q_comb
      assign q_valid = in_valid;
      assign q_cls   = op_class;
      assign q_alu   = alu_sel;
      assign q_msc   = misc_sel;
      assign q_acc   = acc_in;
      assign q_fin   = flags_in;
   end

   // R1
   valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == q_valid);

   // R2
   flag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flags_out[3:0] == 4'h0);

   // R5
   compare_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_cls == CLS_BYTE && q_alu == ALU_CP) |-> (!acc_we && res_byte == q_acc));

   // R6
   and_half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_cls == CLS_BYTE && q_alu == ALU_AND)
         |-> (flags_out[FB_H] && !flags_out[FB_N] && !flags_out[FB_C]));

   // R7
   incdec_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_cls == CLS_MISC && (q_msc == MSC_INC || q_msc == MSC_DEC))
         |-> flags_out[FB_C] == q_fin[0]);

   // R9
   scf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_cls == CLS_MISC && q_msc == MSC_SCF)
         |-> flags_out[7:4] == {q_fin[3], 3'b001});

   // R10
   no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && (q_cls == CLS_NONE
                   || (q_cls == CLS_MISC && (q_msc == MSC_RSV6 || q_msc == MSC_RSV7))))
         |-> (!acc_we && !pair_we && flags_out[7:4] == q_fin && res_byte == q_acc));

   // R11
   word_zero_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_cls == CLS_WORD)
         |-> (pair_we && !acc_we && flags_out[FB_Z] == q_fin[3] && !flags_out[FB_N]));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_acc_alu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_class  (op_class),
   .alu_sel   (alu_sel),
   .misc_sel  (misc_sel),
   .acc_in    (acc_in),
   .flags_in  (flags_in),
   .out_valid (out_valid),
   .acc_we    (acc_we),
   .pair_we   (pair_we),
   .res_byte  (res_byte),
   .flags_out (flags_out)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

   localparam int LANES = 8;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        lv   [LANES];
   logic [1:0]  lcls [LANES];
   logic [2:0]  lalu [LANES];
   logic [2:0]  lmsc [LANES];
   logic [7:0]  lacc [LANES];
   logic [7:0]  lopd [LANES];
   logic [15:0] lpa  [LANES];
   logic [15:0] lpb  [LANES];
   logic [3:0]  lfin [LANES];
   logic        lov  [LANES];
   logic        lawe [LANES];
   logic        lpwe [LANES];
   logic [7:0]  lres [LANES];
   logic [15:0] lrw  [LANES];
   logic [7:0]  lfo  [LANES];

   logic        pend [LANES];
   logic [33:0] expv [LANES];
   string       etag [LANES];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      acc_alu u_acc_alu (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (lv[g]),
         .op_class  (lcls[g]),
         .alu_sel   (lalu[g]),
         .misc_sel  (lmsc[g]),
         .acc_in    (lacc[g]),
         .opnd_in   (lopd[g]),
         .pair_a    (lpa[g]),
         .pair_b    (lpb[g]),
         .flags_in  (lfin[g]),
         .out_valid (lov[g]),
         .acc_we    (lawe[g]),
         .pair_we   (lpwe[g]),
         .res_byte  (lres[g]),
         .res_word  (lrw[g]),
         .flags_out (lfo[g])
      );
   end

   // expected {acc_we, pair_we, res_byte, flags_out, res_word}
   function automatic logic [33:0] ref_out(input logic [1:0] cls, input logic [2:0] as,
                                           input logic [2:0] ms, input logic [7:0] a,
                                           input logic [7:0] b, input logic [3:0] f,
                                           input logic [15:0] pa, input logic [15:0] pb);
      logic z, n, h, c, we, pw, lo, hi;
      logic [7:0]  r;
      logic [15:0] rw;
      int s, cin, t;
      z = f[3]; n = f[2]; h = f[1]; c = f[0];
      we = 1'b0; pw = 1'b0; r = a; rw = 16'h0;
      case (cls)
         2'd0: begin
            cin = ((as == 3'd1) || (as == 3'd3)) ? int'(c) : 0;
            case (as)
               3'd0, 3'd1: begin
                  s = int'(a) + int'(b) + cin;
                  h = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
                  c = s > 255; n = 1'b0; r = 8'(s & 255); we = 1'b1; z = (r == 8'h0);
               end
               3'd2, 3'd3, 3'd7: begin
                  s = int'(a) - int'(b) - cin;
                  h = (int'(a) % 16) < ((int'(b) % 16) + cin);
                  c = s < 0; n = 1'b1; t = s & 255; z = (t == 0);
                  we = (as != 3'd7);
                  r = we ? 8'(t) : a;
               end
               3'd4: begin r = a & b; h = 1'b1; c = 1'b0; n = 1'b0; we = 1'b1; z = (r == 8'h0); end
               3'd5: begin r = a ^ b; h = 1'b0; c = 1'b0; n = 1'b0; we = 1'b1; z = (r == 8'h0); end
               default: begin r = a | b; h = 1'b0; c = 1'b0; n = 1'b0; we = 1'b1; z = (r == 8'h0); end
            endcase
         end
         2'd1: begin
            case (ms)
               3'd0: begin r = a + 8'd1; n = 1'b0; h = (r[3:0] == 4'h0); z = (r == 8'h0); we = 1'b1; end
               3'd1: begin r = a - 8'd1; n = 1'b1; h = (r[3:0] == 4'hF); z = (r == 8'h0); we = 1'b1; end
               3'd2: begin
                  lo = h || (a[3:0] > 4'd9);
                  hi = c || (a > 8'h99);
                  t = (lo ? 6 : 0) + (hi ? 96 : 0);
                  s = n ? (int'(a) - t) : (int'(a) + t);
                  r = 8'(s & 255); c = hi; h = 1'b0; z = (r == 8'h0); we = 1'b1;
               end
               3'd3: begin r = ~a; h = 1'b1; n = 1'b1; we = 1'b1; end
               3'd4: begin c = 1'b1; h = 1'b0; n = 1'b0; end
               3'd5: begin c = ~c; h = 1'b0; n = 1'b0; end
               default: ;
            endcase
         end
         2'd2: begin
            s  = int'(pa) + int'(pb);
            rw = 16'(s & 65535);
            c  = s > 65535;
            h  = ((int'(pa) % 4096) + (int'(pb) % 4096)) > 4095;
            n  = 1'b0; pw = 1'b1;
         end
         default: ;
      endcase
      return {we, pw, r, z, n, h, c, 4'h0, rw};
   endfunction

   function automatic string tag_of(input logic [1:0] cls, input logic [2:0] as, input logic [2:0] ms);
      if (cls == 2'd0) begin
         if (as <= 3'd1) return "R3";
         if (as <= 3'd3) return "R4";
         if (as == 3'd7) return "R5";
         return "R6";
      end
      if (cls == 2'd1) begin
         if (ms <= 3'd1) return "R7";
         if (ms == 3'd2) return "R8";
         if (ms <= 3'd5) return "R9";
         return "R10";
      end
      if (cls == 2'd2) return "R11";
      return "R10";
   endfunction

   // check outputs at a falling edge, then clear the lane strobes
   task automatic tick();
      logic [33:0] got;
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
         checks++;
         if (lov[i] !== pend[i]) begin
            fails++;
            $display("FAIL R1 lane %0d out_valid=%b expected %b", i, lov[i], pend[i]);
         end else if (pend[i]) begin
            got = {lawe[i], lpwe[i], lres[i], lfo[i], lrw[i]};
            if (got !== expv[i]) begin
               fails++;
               $display("FAIL %s lane %0d got %h expected %h", etag[i], i, got, expv[i]);
            end
            checks++;
            if (lfo[i][3:0] !== 4'h0) begin
               fails++;
               $display("FAIL R2 lane %0d flag low nibble %h expected 0", i, lfo[i][3:0]);
            end
         end
         pend[i] = 1'b0;
         lv[i]   = 1'b0;
      end
   endtask

   task automatic drive(input int i, input logic [1:0] cls, input logic [2:0] as,
                        input logic [2:0] ms, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] f, input logic [15:0] pa, input logic [15:0] pb);
      lv[i] = 1'b1; lcls[i] = cls; lalu[i] = as; lmsc[i] = ms;
      lacc[i] = a; lopd[i] = b; lfin[i] = f; lpa[i] = pa; lpb[i] = pb;
      pend[i] = 1'b1;
      expv[i] = ref_out(cls, as, ms, a, b, f, pa, pb);
      etag[i] = tag_of(cls, as, ms);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired, run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] pa, pb;
      for (int i = 0; i < LANES; i++) begin
         lv[i] = 1'b0; pend[i] = 1'b0; lcls[i] = 2'd0; lalu[i] = 3'd0; lmsc[i] = 3'd0;
         lacc[i] = 8'h0; lopd[i] = 8'h0; lfin[i] = 4'h0; lpa[i] = 16'h0; lpb[i] = 16'h0;
         expv[i] = '0; etag[i] = "R1";
      end
      // R1: out_valid low through and just after reset
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R3 R4 R5 R6: every operand pair with both carry inputs, one op per lane
      for (int k = 0; k < 131072; k++) begin
         tick();
         for (int i = 0; i < LANES; i++)
            drive(i, 2'd0, 3'(i), 3'd0, 8'(k), 8'(k >> 8),
                  {k[3] ^ k[11], k[10], k[5] ^ k[12], k[16]}, 16'h0, 16'h0);
      end

      // R7 R8 R9 R10: every accumulator value with every flag combination
      for (int k = 0; k < 4096; k++) begin
         tick();
         for (int i = 0; i < LANES; i++)
            drive(i, 2'd1, 3'(7 - i), 3'(i), 8'(k), 8'(k * 7), 4'(k >> 8), 16'h0, 16'h0);
      end

      // R11: pair additions with boundary pairs first
      for (int k = 0; k < 2000; k++) begin
         tick();
         for (int i = 0; i < LANES; i++) begin
            pa = 16'(k * 40503 + i * 7919);
            pb = 16'(k * 25173 + i * 13849 + 12345);
            if (k == 0) begin
               case (i)
                  0: begin pa = 16'h0FFF; pb = 16'h0001; end
                  1: begin pa = 16'hFFFF; pb = 16'h0001; end
                  2: begin pa = 16'h8000; pb = 16'h8000; end
                  3: begin pa = 16'h0800; pb = 16'h0800; end
                  default: ;
               endcase
            end
            drive(i, 2'd2, 3'(i), 3'(i), 8'(k), 8'(k + i), 4'(k + i), pa, pb);
         end
      end

      // R10 class 3 no-op, R1 strobe gaps on odd cycles
      for (int k = 0; k < 512; k++) begin
         tick();
         if ((k % 2) == 0)
            for (int i = 0; i < LANES; i++)
               drive(i, 2'd3, 3'(k + i), 3'(k >> 3), 8'(k * 3 + i), 8'(k), 4'(k + i),
                     16'(k), 16'(k + 1));
      end

      tick();
      tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule